// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block is the column-access front end of a graphics DRAM model. A mode-register-set command writes its configuration register. That register holds four settings: the burst length (4 or 8), the burst ordering (sequential only), the read latency and the write latency. A read or write command arrives with a column address. The block waits the programmed latency and then presents the burst's column addresses, one per clock. A strobe runs alongside them and marks the first beat and the last beat.

The two lowest column bits of a command are discarded, so every burst starts on a 4-column boundary. In a burst of 8, column bit 2 chooses where the burst starts inside its 8-column block, and the order wraps within that block. A new read or write is taken only once the running burst has reached its last beat. Until then the block reports busy and drops any command that arrives.

Top module: `burst_col_seq`

## Requirements
- R1: After reset, beat_vld, beat_first, beat_last, beat_wr, busy and mode_err are all 0. The mode register then holds burst length 4, read latency 5 and write latency 1.
- R2: A mode-register-set command with legal fields takes effect for commands accepted at later clock edges. The fields are:
  - addr[2:0]: burst length, 3'b010 = 4 and 3'b011 = 8.
  - addr[3]: ordering, must be 0 (sequential).
  - addr[6:4]: write latency, 1 to 7.
  - addr[7]: operating mode, must be 0 (normal).
  - addr[11:8]: read latency, 5 to 10.
- R3: If any of those fields holds another value, the whole mode-register-set command is discarded and the previous settings stay. mode_err is 1 for exactly the one cycle after that edge.
- R4: Column bits addr[1:0] of a read or write have no effect on the column outputs. Within the block, every burst's first column has bits [1:0] = 0.
- R5: A burst of 4 outputs columns {addr[9:2], 2'd0}, then 2'd1, 2'd2 and 2'd3 in the low bits.
- R6: A burst of 8 keeps addr[9:3] as the upper bits. With addr[2]=0 its low three bits run 0,1,2,3,4,5,6,7. With addr[2]=1 they run 4,5,6,7,0,1,2,3.
- R7: A read sampled at clock edge n makes its first beat appear at edge n+CL, where CL is the read latency.
- R8: A write sampled at clock edge n makes its first beat appear at edge n+WL, where WL is the write latency.
- R9: beat_vld is high for exactly burst-length consecutive cycles. beat_first is high only on the first of those cycles and beat_last only on the final one. beat_wr is 1 during a write burst and 0 during a read burst.
- R10: busy is high from the cycle after an accepted command until the cycle before its last beat. A read or write sampled while busy is high is ignored. A read or write sampled during the last-beat cycle is accepted, so bursts can run back to back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_mrs | input | 1 | Mode-register-set command |
| cmd_rd | input | 1 | Read command |
| cmd_wr | input | 1 | Write command |
| addr | input | 12 | Mode value or column address |
| col_out | output | 10 | Column address of the current beat (0 when idle) |
| beat_vld | output | 1 | A burst beat is present |
| beat_first | output | 1 | First beat of the burst |
| beat_last | output | 1 | Last beat of the burst |
| beat_wr | output | 1 | The current burst is a write |
| busy | output | 1 | A command sampled now would be ignored |
| mode_err | output | 1 | The previous mode-register-set command was reserved |

## Verification
Results fall due at different cycles:
- The first beat of a read is due CL edges after the command is sampled, and the first beat of a write is due WL edges after it. Each following beat is due one edge later.
- mode_err is due on the edge that samples the mode-register-set command.
- busy changes on the edge that accepts a command.

The bench works out, at the moment it drives a command, the edge number at which each of these outputs must change, and files the expected values under that edge number. It then compares every output half a clock after each edge against the entry for that edge. Commands are also placed on the edge just before the last beat and on the last-beat edge itself, which covers the rejected case and the back-to-back case.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  // Field layout of the mode word
  localparam int MR_W      = 12;
  localparam int BL_LSB    = 0;
  localparam int ORD_BIT   = 3;
  localparam int WL_LSB    = 4;
  localparam int OPM_BIT   = 7;
  localparam int CL_LSB    = 8;

  localparam logic [2:0] BL_CODE4 = 3'b010;
  localparam logic [2:0] BL_CODE8 = 3'b011;
  localparam int CL_MIN = 5;
  localparam int CL_MAX = 10;

  typedef struct packed {
    logic       bl8;
    logic [3:0] rd_lat;
    logic [2:0] wr_lat;
  } bcs_mode_t;

  localparam bcs_mode_t MODE_RST = '{bl8: 1'b0, rd_lat: 4'd5, wr_lat: 3'd1};

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BURST = 2'd2
  } bcs_state_t;

  function automatic logic mode_word_ok(input logic [MR_W-1:0] w);
    logic [2:0] blc;
    logic [3:0] cl;
    logic [2:0] wl;
    blc = w[BL_LSB +: 3];
    cl  = w[CL_LSB +: 4];
    wl  = w[WL_LSB +: 3];
    return ((blc == BL_CODE4) || (blc == BL_CODE8)) &&
           !w[ORD_BIT] && !w[OPM_BIT] && (wl != 3'd0) &&
           (int'(cl) >= CL_MIN) && (int'(cl) <= CL_MAX);
  endfunction

endpackage

// File: rtl/bcs_mode_reg.sv
module bcs_mode_reg
  import bcs_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            mrs_req,
  input  logic [MR_W-1:0] mrs_word,
  output bcs_mode_t       mode_q,
  output logic            err_q
);

  logic      word_ok;
  logic      mode_en;
  bcs_mode_t mode_d;
  logic      err_d;

  always_comb begin
    word_ok       = mode_word_ok(mrs_word);
    mode_en       = mrs_req && word_ok;
    err_d         = mrs_req && !word_ok;
    mode_d.bl8    = mrs_word[BL_LSB];
    mode_d.rd_lat = mrs_word[CL_LSB +: 4];
    mode_d.wr_lat = mrs_word[WL_LSB +: 3];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_RST;
    end else if (mode_en) begin
      mode_q <= mode_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  // R3: a reserved word leaves the settings untouched
  a_r3_hold_on_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    err_q |-> (mode_q == $past(mode_q)));

  // R2: the register only ever holds legal latencies
  a_r2_legal_latency: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(mode_q.rd_lat) >= CL_MIN) && (int'(mode_q.rd_lat) <= CL_MAX) && (mode_q.wr_lat != 3'd0));

endmodule

// File: rtl/bcs_cmd_ctl.sv
module bcs_cmd_ctl
  import bcs_pkg::*;
#(
  parameter int LAT_W = 4,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_req,
  input  logic             wr_req,
  input  bcs_mode_t        mode,
  output logic             accept,
  output logic             busy,
  output logic             beat_vld,
  output logic             beat_first,
  output logic             beat_last,
  output logic             beat_wr,
  output logic             bl8_q,
  output logic [IDX_W-1:0] idx_q
);

  localparam logic [IDX_W-1:0] LAST4 = IDX_W'(3);
  localparam logic [IDX_W-1:0] LAST8 = IDX_W'(7);

  bcs_state_t       st_q, st_d;
  logic [LAT_W-1:0] cnt_q, cnt_d;
  logic [IDX_W-1:0] idx_d;
  logic             bl8_d;
  logic             wr_q, wr_d;
  logic             at_last;
  logic             ready;
  logic [LAT_W-1:0] lat_sel;

  always_comb begin
    at_last = (st_q == ST_BURST) && (idx_q == (bl8_q ? LAST8 : LAST4));
    ready   = (st_q == ST_IDLE) || at_last;
    accept  = ready && (rd_req || wr_req);
    lat_sel = rd_req ? LAT_W'(mode.rd_lat) : LAT_W'(mode.wr_lat);
  end

  // next-state
  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    idx_d = idx_q;
    bl8_d = bl8_q;
    wr_d  = wr_q;
    if (accept) begin
      st_d  = ST_WAIT;
      cnt_d = lat_sel - LAT_W'(1);
      idx_d = '0;
      bl8_d = mode.bl8;
      wr_d  = !rd_req;
    end else begin
      unique case (st_q)
        ST_WAIT: begin
          if (cnt_q == '0) begin
            st_d  = ST_BURST;
            idx_d = '0;
          end else begin
            cnt_d = cnt_q - LAT_W'(1);
          end
        end
        ST_BURST: begin
          if (at_last) st_d = ST_IDLE;
          else         idx_d = idx_q + IDX_W'(1);
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      idx_q <= '0;
      bl8_q <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
      idx_q <= idx_d;
      bl8_q <= bl8_d;
      wr_q  <= wr_d;
    end
  end

  always_comb begin
    beat_vld   = (st_q == ST_BURST);
    beat_first = beat_vld && (idx_q == '0);
    beat_last  = at_last;
    beat_wr    = beat_vld && wr_q;
    busy       = !ready;
  end

  // R9: a burst runs without gaps and starts only once
  a_r9_contiguous: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !beat_last) |=> (beat_vld && !beat_first));

  // R9: the first and last beats never coincide (length is at least 4)
  a_r9_first_not_last: assert property (@(posedge clk) disable iff (!rst_n)
    beat_first |-> !beat_last);

  // R10: once busy clears after a burst, nothing is left running
  a_r10_idle_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_last && !rd_req && !wr_req) |=> (!beat_vld && !busy));

endmodule

// File: rtl/bcs_col_gen.sv
module bcs_col_gen #(
  parameter int COL_W = 10,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [COL_W-1:0] cmd_col,
  input  logic             bl8,
  input  logic             vld,
  input  logic [IDX_W-1:0] idx,
  output logic [COL_W-1:0] col
);

  localparam int BASE_W = COL_W - 2;

  logic [BASE_W-1:0] base_q;
  logic [COL_W-1:0]  col_b4, col_b8;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
    end else if (load) begin
      base_q <= cmd_col[COL_W-1:2];
    end
  end

  always_comb begin
    col_b4 = {base_q, idx[1:0]};
    col_b8 = {base_q[BASE_W-1:1], base_q[0] ^ idx[2], idx[1:0]};
    col    = !vld ? '0 : (bl8 ? col_b8 : col_b4);
  end

  // R4: the first beat of every burst is 4-column aligned
  a_r4_first_aligned: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && (idx == '0)) |-> (col[1:0] == 2'd0));

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int COL_W  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_mrs,
  input  logic              cmd_rd,
  input  logic              cmd_wr,
  input  logic [ADDR_W-1:0] addr,
  output logic [COL_W-1:0]  col_out,
  output logic              beat_vld,
  output logic              beat_first,
  output logic              beat_last,
  output logic              beat_wr,
  output logic              busy,
  output logic              mode_err
);

  localparam int IDX_W = 3;
  localparam int LAT_W = 4;

  bcs_mode_t        mode_q;
  logic             accept;
  logic             bl8_q;
  logic [IDX_W-1:0] idx_q;

  bcs_mode_reg i_mode (
    .clk      (clk),
    .rst_n    (rst_n),
    .mrs_req  (cmd_mrs),
    .mrs_word (addr[MR_W-1:0]),
    .mode_q   (mode_q),
    .err_q    (mode_err)
  );

  bcs_cmd_ctl #(.LAT_W(LAT_W), .IDX_W(IDX_W)) i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .rd_req     (cmd_rd),
    .wr_req     (cmd_wr),
    .mode       (mode_q),
    .accept     (accept),
    .busy       (busy),
    .beat_vld   (beat_vld),
    .beat_first (beat_first),
    .beat_last  (beat_last),
    .beat_wr    (beat_wr),
    .bl8_q      (bl8_q),
    .idx_q      (idx_q)
  );

  bcs_col_gen #(.COL_W(COL_W), .IDX_W(IDX_W)) i_col (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .cmd_col (addr[COL_W-1:0]),
    .bl8     (bl8_q),
    .vld     (beat_vld),
    .idx     (idx_q),
    .col     (col_out)
  );

  // R5: the low two column bits step by one from beat to beat
  a_r5_low_step: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !beat_first) |-> (col_out[1:0] == $past(col_out[1:0]) + 2'd1));

  // R6: a burst never leaves its 8-column block
  a_r6_same_block: assert property (@(posedge clk) disable iff (!rst_n)
    (beat_vld && !beat_first) |-> (col_out[COL_W-1:3] == $past(col_out[COL_W-1:3])));

endmodule

// File: tb/test_burst_col_seq.sv
module test_burst_col_seq;
  localparam int HZ = 64;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cmd_mrs, cmd_rd, cmd_wr;
  logic [11:0] addr;
  logic [9:0]  col_out;
  logic        beat_vld, beat_first, beat_last, beat_wr, busy, mode_err;

  burst_col_seq i_burst_col_seq (
    .clk(clk), .rst_n(rst_n), .cmd_mrs(cmd_mrs), .cmd_rd(cmd_rd), .cmd_wr(cmd_wr),
    .addr(addr), .col_out(col_out), .beat_vld(beat_vld), .beat_first(beat_first),
    .beat_last(beat_last), .beat_wr(beat_wr), .busy(busy), .mode_err(mode_err)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int last_edge = -1;
  bit done = 1'b0;
  bit m_bl8 = 1'b0;
  int m_cl = 5;
  int m_wl = 1;

  bit       e_vld[HZ], e_first[HZ], e_last[HZ], e_wr[HZ], e_busy[HZ], e_err[HZ];
  bit [9:0] e_col[HZ];

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cycle %0d act=%0d exp=%0d", req, what, cyc, act, exp);
    end
  endtask

  // R2/R3: legality of a mode word
  function automatic bit mr_legal(input logic [11:0] w);
    return ((w[2:0] == 3'b010) || (w[2:0] == 3'b011)) && !w[3] && !w[7] &&
           (w[6:4] != 3'd0) && (w[11:8] >= 4'd5) && (w[11:8] <= 4'd10);
  endfunction

  // R5/R6: expected column of beat k
  function automatic bit [9:0] exp_col(input logic [11:0] a, input bit bl8, input int k);
    bit [2:0] kk;
    kk = 3'(k);
    if (bl8) return {a[9:3], a[2] ^ kk[2], kk[1:0]};
    return {a[9:2], kk[1:0]};
  endfunction

  function automatic logic [11:0] mr_word(input bit bl8, input int cl, input int wl);
    return {4'(cl), 1'b0, 3'(wl), 1'b0, 2'b01, bl8};
  endfunction

  task automatic step(input bit mrs, input bit rd, input bit wr, input logic [11:0] a);
    int n, ix, lat, bl;
    n = cyc + 1;
    cmd_mrs = mrs; cmd_rd = rd; cmd_wr = wr; addr = a;
    // R10: accepted only from the last-beat edge onwards
    if ((rd || wr) && (n >= last_edge + 1)) begin
      lat = rd ? m_cl : m_wl;  // R7/R8
      bl  = m_bl8 ? 8 : 4;
      for (int k = 0; k < bl; k++) begin
        ix = (n + lat + k) % HZ;
        e_vld[ix]   = 1'b1;
        e_first[ix] = (k == 0);
        e_last[ix]  = (k == bl - 1);
        e_wr[ix]    = !rd;
        e_col[ix]   = exp_col(a, m_bl8, k);
      end
      for (int e = n; e <= n + lat + bl - 2; e++) e_busy[e % HZ] = 1'b1;
      last_edge = n + lat + bl - 1;
    end
    if (mrs) begin
      if (mr_legal(a)) begin
        m_bl8 = a[0]; m_cl = int'(a[11:8]); m_wl = int'(a[6:4]);
      end else begin
        e_err[n % HZ] = 1'b1;
      end
    end
    @(posedge clk);
    cyc = n;
    @(negedge clk);
    cmd_mrs = 1'b0; cmd_rd = 1'b0; cmd_wr = 1'b0;
    ix = n % HZ;
    chk(beat_vld == e_vld[ix], "R7/R8/R9", "beat_vld", int'(beat_vld), int'(e_vld[ix]));
    chk(beat_first == e_first[ix], "R9", "beat_first", int'(beat_first), int'(e_first[ix]));
    chk(beat_last == e_last[ix], "R9", "beat_last", int'(beat_last), int'(e_last[ix]));
    chk(beat_wr == e_wr[ix], "R9", "beat_wr", int'(beat_wr), int'(e_wr[ix]));
    chk(busy == e_busy[ix], "R10", "busy", int'(busy), int'(e_busy[ix]));
    chk(mode_err == e_err[ix], "R3", "mode_err", int'(mode_err), int'(e_err[ix]));
    if (e_vld[ix]) chk(col_out == e_col[ix], "R4/R5/R6", "col_out", int'(col_out), int'(e_col[ix]));
    e_vld[ix] = 0; e_first[ix] = 0; e_last[ix] = 0; e_wr[ix] = 0; e_busy[ix] = 0; e_err[ix] = 0;
  endtask

  task automatic idle(input int cnt);
    for (int i = 0; i < cnt; i++) step(1'b0, 1'b0, 1'b0, 12'h000);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      errors++;
      $display("FAIL R9 watchdog act=0 exp=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int i = 0; i < HZ; i++) begin
      e_vld[i] = 0; e_first[i] = 0; e_last[i] = 0; e_wr[i] = 0; e_busy[i] = 0; e_err[i] = 0; e_col[i] = '0;
    end
    rst_n = 1'b0; cmd_mrs = 0; cmd_rd = 0; cmd_wr = 0; addr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    chk(!beat_vld && !beat_first && !beat_last && !beat_wr, "R1", "strobes", int'(beat_vld), 0);
    chk(!busy, "R1", "busy", int'(busy), 0);
    chk(!mode_err, "R1", "mode_err", int'(mode_err), 0);
    idle(2);
    // R1/R4/R5/R7: default burst 4, read latency 5, low address bits set
    step(0, 1, 0, 12'h2B7);
    idle(12);
    // R8: default write latency 1
    step(0, 0, 1, 12'h0F1);
    idle(8);
    // R2/R6: burst 8, CL 7, WL 3, both starting halves
    step(1, 0, 0, mr_word(1, 7, 3));
    step(0, 1, 0, 12'h3A6);
    idle(18);
    step(0, 0, 1, 12'h1C2);
    idle(14);
    // R3: reserved length code, ordering bit, mode bit, CL 11, WL 0
    step(1, 0, 0, 12'h531);
    step(1, 0, 0, mr_word(0, 5, 1) | 12'h008);
    step(1, 0, 0, mr_word(0, 5, 1) | 12'h080);
    step(1, 0, 0, mr_word(0, 11, 1));
    step(1, 0, 0, mr_word(0, 5, 0));
    step(1, 0, 0, mr_word(0, 4, 2));
    // R3: settings kept (still burst 8, CL 7)
    step(0, 1, 0, 12'h0AC);
    // R10: rejected mid-burst, rejected one edge early, accepted on last-beat edge
    step(0, 0, 1, 12'h155);
    while (cyc + 1 < last_edge) step(0, 0, 0, 12'h000);
    step(0, 1, 0, 12'h222);
    step(0, 0, 1, 12'h3FC);
    // R8/R10: shortest write latency back to back
    idle(20);
    step(1, 0, 0, mr_word(1, 10, 1));
    step(0, 0, 1, 12'h014);
    while (cyc + 1 < last_edge + 1) step(0, 0, 0, 12'h000);
    step(0, 0, 1, 12'h018);
    idle(20);
    // random mix
    for (int i = 0; i < 2500; i++) begin
      int r;
      logic [11:0] w;
      r = int'($urandom_range(99));
      if (r < 4) begin
        w = mr_word(1'($urandom_range(1)), int'($urandom_range(10, 5)), int'($urandom_range(7, 1)));
        if ($urandom_range(3) == 0) w[$urandom_range(11)] = ~w[$urandom_range(11)];
        step(1, 0, 0, w);
      end else if (r < 34) begin
        bit rd;
        rd = 1'($urandom_range(1));
        step(0, rd, !rd, 12'($urandom));
      end else begin
        step(0, 0, 0, 12'h000);
      end
    end
    idle(30);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule